// File: doc/BRIEF.md
# Scaled Indexed Effective-Address Generator

This block forms the 16-bit data address for an 8-bit processor whose memory port is one byte wide. A request names an addressing mode, a base source, an index source and a scale code. The block answers with a registered address and a one-cycle completion strobe. Modes without indirection answer in the cycle after the request. The two pointer-based modes first read a 16-bit pointer over the byte port, one byte at a time, and then form the address from it.

Supported forms are: absolute from the immediate field, through a 16-bit register, through a pointer held in memory, base plus scaled index, stack-relative with a scaled index, program-counter-relative with a short signed displacement, and pointer plus scaled index. All operands are captured on the cycle a request is accepted. Later changes to the inputs do not affect a request that is already running.

Top module: `eff_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it rises with no request, done_o and mem_rd_o are 0 and addr_o is 0.
- R2: Mode codes 0 (absolute: addr = imm_i), 1 (register: addr = reg_base_i) and reserved code 7 (treated as absolute) set addr_o and raise done_o in the cycle after the accepting clock edge, so a new request can be accepted every cycle.
- R3: The index (idx_const_i when idx_sel_i = 0, idx_reg_i when 1) is shifted left by scale_i for codes 0 to 4 (x1, x2, x4, x8, x16). Codes 5 to 7 act as code 4. Bits shifted past bit 15 are lost.
- R4: Mode 3 gives base + scaled index. The base is picked by base_sel_i: 0 immediate, 1 register, 2 stack pointer, 3 program counter.
- R5: Mode 4 gives sp_i + scaled index, whatever base_sel_i is.
- R6: Mode 5 gives pc_i + disp_i, with disp_i sign-extended from 8 bits.
- R7: All address sums wrap modulo 2^16, including the pointer-byte address.
- R8: Mode 2 reads the pointer low byte at the location picked by base_sel_i and the high byte at location + 1, in two consecutive mem_rd_o cycles. Read data arrives on mem_rdata_i in the cycle after each read. done_o rises four cycles after the accepting edge, with addr_o equal to the pointer.
- R9: Mode 6 follows the same fetch sequence as R8 and gives pointer + scaled index.
- R10: Each accepted request produces exactly one done_o cycle. done_o is never high otherwise.
- R11: start_i is ignored while a pointer fetch is in progress, up to and including the cycle before done_o.
- R12: mem_rd_o is high for exactly two cycles per pointer-based request and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 2 | Base source select |
| imm_i | input | 16 | Immediate address field |
| reg_base_i | input | 16 | 16-bit register operand |
| sp_i | input | 16 | Stack pointer value |
| pc_i | input | 16 | Program counter value |
| idx_sel_i | input | 1 | Index source: 0 constant, 1 register |
| idx_const_i | input | 16 | Constant index |
| idx_reg_i | input | 16 | Register index |
| scale_i | input | 3 | Index scale code |
| disp_i | input | 8 | Signed PC displacement |
| mem_addr_o | output | 16 | Pointer byte read address |
| mem_rd_o | output | 1 | Pointer byte read strobe |
| mem_rdata_i | input | 8 | Read data, one cycle after mem_rd_o |
| addr_o | output | 16 | Effective address |
| done_o | output | 1 | Address valid strobe |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- Scale codes above 4. A design that passes these codes through would compute x32 or more.
- A negative displacement and a displacement that crosses 0x0000. A design that zero-extends the displacement would land 256 bytes too high.
- A pointer stored at 0xFFFF. A design with a carry into bit 16 of the byte address would not wrap its high-byte read to 0x0000.
- Requests held high during a fetch while the operand inputs change. A design that re-samples operands mid-fetch would produce a wrong address, and one that accepts these requests would produce a stray done_o.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    M_ABS      = 3'd0,
    M_REG      = 3'd1,
    M_PTR      = 3'd2,
    M_BASE_IDX = 3'd3,
    M_SP_IDX   = 3'd4,
    M_PC_DISP  = 3'd5,
    M_PTR_IDX  = 3'd6,
    M_RSVD     = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    B_IMM = 2'd0,
    B_REG = 2'd1,
    B_SP  = 2'd2,
    B_PC  = 2'd3
  } ea_base_e;
endpackage

// File: rtl/ea_scaler.sv
module ea_scaler #(
  parameter int unsigned W      = 16,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned MAX_SH = 4
) (
  input  logic [W-1:0]      val_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [W-1:0]      val_o
);
  logic [W-1:0] shifted [MAX_SH+1];

  for (genvar s = 0; s <= MAX_SH; s++) begin : g_sh
    assign shifted[s] = val_i << s;
  end

  // codes above MAX_SH saturate to the largest shift
  always_comb begin
    val_o = shifted[MAX_SH];
    for (int s = 0; s <= MAX_SH; s++) begin
      if (code_i == CODE_W'(s)) val_o = shifted[s];
    end
  end
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // modulo 2^W, carry dropped
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] loc_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          ptr_vld_o,
  output logic          busy_o
);
  localparam int unsigned NB = AW / DW;
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [1:0] {F_IDLE, F_RD, F_FIN} fstate_e;

  fstate_e                  state_q;
  logic [CW-1:0]            cnt_q;
  logic [AW-1:0]            loc_q;
  logic [NB-2:0][DW-1:0]    bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      cnt_q   <= '0;
      loc_q   <= '0;
      bytes_q <= '0;
    end else begin
      unique case (state_q)
        F_IDLE: if (go_i) begin
          loc_q   <= loc_i;
          cnt_q   <= '0;
          state_q <= F_RD;
        end
        F_RD: begin
          // data for the previous read arrives now
          if (cnt_q != '0) bytes_q[cnt_q - CW'(1)] <= mem_rdata_i;
          if (cnt_q == CW'(NB-1)) state_q <= F_FIN;
          else                    cnt_q   <= cnt_q + CW'(1);
        end
        F_FIN:   state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign mem_addr_o = loc_q + AW'(cnt_q);
  assign mem_rd_o   = (state_q == F_RD);
  assign ptr_o      = {mem_rdata_i, bytes_q};
  assign ptr_vld_o  = (state_q == F_FIN);
  assign busy_o     = (state_q != F_IDLE);
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned SCALE_W = 3,
  parameter int unsigned MAX_SH  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         mode_i,
  input  logic [1:0]         base_sel_i,
  input  logic [AW-1:0]      imm_i,
  input  logic [AW-1:0]      reg_base_i,
  input  logic [AW-1:0]      sp_i,
  input  logic [AW-1:0]      pc_i,
  input  logic               idx_sel_i,
  input  logic [AW-1:0]      idx_const_i,
  input  logic [AW-1:0]      idx_reg_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DISP_W-1:0]  disp_i,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_rd_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [AW-1:0]      addr_o,
  output logic               done_o
);
  ea_mode_e      mode;
  ea_base_e      bsel;
  logic [AW-1:0] base_sel_val, idx_val, idx_scaled, disp_ext;
  logic [AW-1:0] base_now, off_now, off_q;
  logic [AW-1:0] add_a, add_b, sum;
  logic [AW-1:0] ptr;
  logic          ind_w, accept_w, busy_w, ptr_vld_w;
  logic [AW-1:0] addr_q;
  logic          done_q;

  assign mode = ea_mode_e'(mode_i);
  assign bsel = ea_base_e'(base_sel_i);

  always_comb begin
    unique case (bsel)
      B_IMM:   base_sel_val = imm_i;
      B_REG:   base_sel_val = reg_base_i;
      B_SP:    base_sel_val = sp_i;
      default: base_sel_val = pc_i;
    endcase
  end

  assign idx_val  = idx_sel_i ? idx_reg_i : idx_const_i;
  assign disp_ext = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  ea_scaler #(.W(AW), .CODE_W(SCALE_W), .MAX_SH(MAX_SH)) i_scaler (
    .val_i  (idx_val),
    .code_i (scale_i),
    .val_o  (idx_scaled)
  );

  always_comb begin
    ind_w    = 1'b0;
    base_now = imm_i;
    off_now  = '0;
    unique case (mode)
      M_ABS:      ;
      M_REG:      base_now = reg_base_i;
      M_PTR:      ind_w = 1'b1;
      M_BASE_IDX: begin base_now = base_sel_val; off_now = idx_scaled; end
      M_SP_IDX:   begin base_now = sp_i;         off_now = idx_scaled; end
      M_PC_DISP:  begin base_now = pc_i;         off_now = disp_ext;   end
      M_PTR_IDX:  begin ind_w = 1'b1;            off_now = idx_scaled; end
      default:    ;
    endcase
  end

  assign accept_w = start_i && !busy_w;

  ea_ptr_fetch #(.AW(AW), .DW(DW)) i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (accept_w && ind_w),
    .loc_i       (base_sel_val),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_rdata_i (mem_rdata_i),
    .ptr_o       (ptr),
    .ptr_vld_o   (ptr_vld_w),
    .busy_o      (busy_w)
  );

  // one adder shared by the direct path and the post-fetch path
  assign add_a = ptr_vld_w ? ptr   : base_now;
  assign add_b = ptr_vld_w ? off_q : off_now;

  ea_adder #(.W(AW)) i_adder (
    .a_i   (add_a),
    .b_i   (add_b),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
      off_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (ptr_vld_w) begin
        addr_q <= sum;
        done_q <= 1'b1;
      end else if (accept_w) begin
        if (ind_w) begin
          off_q <= off_now;
        end else begin
          addr_q <= sum;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/ea_checker.sv
module ea_checker #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DISP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [AW-1:0]     imm_i,
  input logic [AW-1:0]     pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              busy_i,
  input logic              ptr_vld_i,
  input logic              ind_i,
  input logic              mem_rd_i,
  input logic [AW-1:0]     mem_addr_i,
  input logic              done_i,
  input logic [AW-1:0]     addr_i
);
  AST_ABS_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && mode_i == 3'd0 |=> done_i && addr_i == $past(imm_i)); // R2

  AST_PC_DISP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && mode_i == 3'd5 |=>
      addr_i == $past(pc_i) + {{(AW-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}); // R6

  AST_PTR_BYTE_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i && $past(mem_rd_i) |-> mem_addr_i == $past(mem_addr_i) + AW'(1)); // R8

  AST_PTR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_rd_i) |=> done_i); // R8

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(ptr_vld_i) || $past(start_i && !busy_i && !ind_i)); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_i && !ptr_vld_i |=> !done_i); // R11

  AST_READ_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i && $past(mem_rd_i) |=> !mem_rd_i); // R12

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_rd_i); // R12
endmodule

bind eff_addr_gen ea_checker #(.AW(AW), .DISP_W(DISP_W)) i_ea_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .imm_i      (imm_i),
  .pc_i       (pc_i),
  .disp_i     (disp_i),
  .busy_i     (busy_w),
  .ptr_vld_i  (ptr_vld_w),
  .ind_i      (ind_w),
  .mem_rd_i   (mem_rd_o),
  .mem_addr_i (mem_addr_o),
  .done_i     (done_o),
  .addr_i     (addr_o)
);

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  bsel = '0;
  logic [15:0] imm = '0, rb = '0, sp = '0, pc = '0, ic = '0, ir = '0;
  logic        isel = 1'b0;
  logic [2:0]  sc = '0;
  logic [7:0]  disp = '0;
  logic [15:0] mem_addr, addr;
  logic        mem_rd, done;
  logic [7:0]  rdata = '0;

  typedef struct {
    logic [15:0] addr;
    int          cyc;
    int          rds;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0, rd_cnt = 0, checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  eff_addr_gen i_eff_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .base_sel_i(bsel),
    .imm_i(imm), .reg_base_i(rb), .sp_i(sp), .pc_i(pc), .idx_sel_i(isel),
    .idx_const_i(ic), .idx_reg_i(ir), .scale_i(sc), .disp_i(disp),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(rdata),
    .addr_o(addr), .done_o(done)
  );

  function automatic logic [7:0] fb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // registered memory: data one cycle after the read strobe
  always @(posedge clk) if (mem_rd) rdata <= fb(mem_addr);
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model();
    logic [15:0] bv, sidx, lp;
    int sh;
    sh   = (sc > 3'd4) ? 4 : int'(sc);
    sidx = (isel ? ir : ic) << sh;
    case (bsel)
      2'd0: bv = imm;
      2'd1: bv = rb;
      2'd2: bv = sp;
      default: bv = pc;
    endcase
    lp = bv + 16'd1;
    case (mode)
      3'd1: return rb;
      3'd2: return {fb(lp), fb(bv)};
      3'd3: return bv + sidx;
      3'd4: return sp + sidx;
      3'd5: return pc + {{8{disp[7]}}, disp};
      3'd6: return {fb(lp), fb(bv)} + sidx;
      default: return imm;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic go(input string tag);
    item_t it;
    logic ind;
    ind    = (mode == 3'd2) || (mode == 3'd6);
    it.addr = model();
    it.cyc  = cyc + (ind ? 4 : 1);
    it.rds  = ind ? 2 : 0;
    it.tag  = tag;
    q.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ind) repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) rd_cnt++;
      if (done) begin
        if (q.size() == 0) begin
          check("R10 unexpected done", 32'(done), 32'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          check({it.tag, " addr"}, 32'(addr), 32'(it.addr));
          check({it.tag, " latency R2/R8"}, 32'(cyc), 32'(it.cyc));
          check({it.tag, " R12 read count"}, 32'(rd_cnt), 32'(it.rds));
          rd_cnt = 0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 mem_rd after reset", 32'(mem_rd), 32'd0);
    check("R1 addr after reset", 32'(addr), 32'd0);

    // R2 absolute, register, reserved code, back to back
    mode = 3'd0; imm = 16'h1234; go("R2 absolute");
    mode = 3'd1; rb = 16'hBEEF;  go("R2 register");
    mode = 3'd7; imm = 16'h0F0F; go("R2 reserved code");

    // R3 R4 every scale code on an immediate base
    mode = 3'd3; bsel = 2'd0; imm = 16'h1000; isel = 1'b0; ic = 16'h0003;
    for (int s = 0; s < 8; s++) begin
      sc = 3'(s);
      go("R3 scale code");
    end
    // R3 bits past bit 15 are lost
    ic = 16'h9001; sc = 3'd1; go("R3 shift truncation");
    // R4 register base, register index, each base select
    isel = 1'b1; ir = 16'h0011; sc = 3'd2;
    rb = 16'h4000; sp = 16'h7000; pc = 16'h0200;
    bsel = 2'd1; go("R4 reg base");
    bsel = 2'd2; go("R4 sp base");
    bsel = 2'd3; go("R4 pc base");

    // R5 stack relative ignores base_sel
    mode = 3'd4; bsel = 2'd0; sp = 16'h8000; isel = 1'b0; ic = 16'h0005; sc = 3'd2;
    go("R5 sp relative");

    // R6 positive and negative displacement, R7 wrap
    mode = 3'd5; pc = 16'h0400; disp = 8'h10; go("R6 disp positive");
    disp = 8'hF0; go("R6 disp negative");
    pc = 16'h0005; disp = 8'h80; go("R7 pc wrap below zero");
    mode = 3'd3; bsel = 2'd0; imm = 16'hFFF0; ic = 16'h0020; sc = 3'd0; go("R7 index wrap");

    // R8 pointer fetch, including a pointer at 0xFFFF (R7)
    mode = 3'd2; bsel = 2'd0; imm = 16'h2000; go("R8 pointer");
    imm = 16'hFFFF; go("R7 pointer byte wrap");
    // R9 pointer plus scaled index, location from register
    mode = 3'd6; bsel = 2'd1; rb = 16'h3000; isel = 1'b1; ir = 16'h0007; sc = 3'd3;
    go("R9 pointer indexed");

    // R11 requests held during a fetch, operands changed
    mode = 3'd6; bsel = 2'd0; imm = 16'h5555; isel = 1'b0; ic = 16'h0002; sc = 3'd1;
    begin
      item_t it;
      it.addr = model(); it.cyc = cyc + 4; it.rds = 2; it.tag = "R11 fetch under requests";
      q.push_back(it);
    end
    start = 1'b1;
    @(negedge clk);
    mode = 3'd0; imm = 16'hAAAA; ic = 16'h7777; sc = 3'd4;
    repeat (3) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R11 addr after ignored requests", 32'(addr), 32'(16'hAAAA) ^ 32'(16'hAAAA) ^ 32'({fb(16'h5556), fb(16'h5555)} + 16'h0004));

    // a final plain request after the fetch
    mode = 3'd0; imm = 16'hC0DE; go("R2 after fetch");
    repeat (6) @(negedge clk);
    check("R10 no outstanding results", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule